// File: doc/BRIEF.md
# Page-Offset-Indexed Cache Lookup Controller

This block serves processor loads from a small physically tagged, direct-mapped cache of 1024 one-word lines (4 KB). It starts the cache array read at the same time as address translation. The line index and the byte-in-word bits come only from the 12-bit page displacement, and translation never changes those bits. So the tag and data arrays are read with the virtual address in the cycle a request is accepted. In the next cycle the stored physical tag is compared against the frame number that the translation buffer returns for the same request.

Each accepted request produces exactly one outcome, one cycle after acceptance:
- **Hit:** the data word is returned.
- **Cache miss with translation hit:** a memory read is issued with the translated physical address.
- **Translation miss:** the request is handed off for a full page-table translation, and the cache is left alone.

Only one cache miss can be outstanding at a time. While it is outstanding the request-ready output stays low. When the memory word comes back, the controller writes the word and its physical tag into the line, re-reads the line, and delivers the hit.

Top module: `pidx_cache_ctrl`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, and none of `resp_valid`, `mem_req_valid` or `xlate_req_valid` is asserted; the first access to any line is a miss.
- R2: Line index is `req_vaddr[11:2]`; bits `[1:0]` select nothing. When the line is valid, the translation hits and the stored 20-bit tag equals the translated frame number, `resp_valid` is 1 with the stored word in the cycle after acceptance.
- R3: When translation hits but the line is invalid or its tag differs, `mem_req_valid` is 1 in the cycle after acceptance. `mem_req_paddr` is then {frame[19:0], vaddr[11:2], 2'b00}.
- R4: When translation misses, `xlate_req_valid` is 1 with the full virtual address in the cycle after acceptance. No memory request and no data response are produced, and the cache contents are unchanged.
- R5: From the cycle after a memory request until the refill completes, `req_ready` is 0 and no request is accepted.
- R6: A `mem_resp_valid` pulse writes `mem_resp_data` and the pending frame number into the pending line. `resp_valid` with that word follows two cycles after the pulse.
- R7: In any cycle at most one of `resp_valid`, `mem_req_valid` and `xlate_req_valid` is 1.
- R8: A line holding one page's tag misses for a different page that has the same displacement. The refill replaces the line, so the first page then misses again.
- R9: Two virtual pages that translate to the same frame share the line at a given displacement: after one fills it, the other hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_vaddr | input | 32 | Virtual byte address of the load |
| req_ready | output | 1 | Request accepted on this edge when high with `req_valid` |
| tlb_query_valid | output | 1 | A lookup is in its compare cycle |
| tlb_query_vpn | output | 20 | Virtual page number sent to the translation buffer |
| tlb_hit | input | 1 | Translation buffer holds the page (same cycle as the query) |
| tlb_ppn | input | 20 | Translated physical frame number |
| resp_valid | output | 1 | Hit data valid |
| resp_data | output | 32 | Hit data word |
| mem_req_valid | output | 1 | One-cycle memory read request |
| mem_req_paddr | output | 32 | Word-aligned physical address for the read |
| mem_resp_valid | input | 1 | Refill word present (one cycle) |
| mem_resp_data | input | 32 | Refill word |
| xlate_req_valid | output | 1 | One-cycle request for a full translation |
| xlate_req_vaddr | output | 32 | Virtual address needing the full translation |

## Verification
The assertions take three things for granted about the inputs:
- The translation buffer answers combinationally from `tlb_query_vpn`, and its answer for a page stays the same for the whole run. This is what lets the replay after a refill end in a hit two cycles later.
- `mem_resp_valid` pulses only while a miss is pending.
- `mem_resp_valid` never arrives in the same cycle as its own request.

The bench meets these assumptions as follows:
- Its translation model is a fixed function of the page number: pages ending in hex F miss, and the others map to a frame built from the upper page bits.
- Its memory model answers each request exactly once, three cycles after it sees the request.

// File: rtl/pidx_pkg.sv
package pidx_pkg;

    // Address geometry; the line index is derived so it always fits inside the page displacement.
    localparam int ADDR_W     = 32;
    localparam int PAGE_OFF_W = 12;
    localparam int OFF_W      = 2;
    localparam int INDEX_W    = PAGE_OFF_W - OFF_W;
    localparam int PPN_W      = ADDR_W - PAGE_OFF_W;
    localparam int DATA_W     = 8 << OFF_W;
    localparam int LINES      = 1 << INDEX_W;

    typedef logic [ADDR_W-1:0]  vaddr_t;
    typedef logic [PPN_W-1:0]   ppn_t;
    typedef logic [INDEX_W-1:0] index_t;
    typedef logic [DATA_W-1:0]  word_t;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_WAIT,
        ST_REPLAY
    } ctl_state_e;

    typedef enum logic [1:0] {
        OUT_NONE,
        OUT_HIT,
        OUT_FILL,
        OUT_WALK
    } outcome_e;

    typedef struct packed {
        logic   valid;
        vaddr_t vaddr;
    } stage_t;

    typedef struct packed {
        vaddr_t vaddr;
        ppn_t   ppn;
    } pending_t;

    function automatic index_t line_index(input vaddr_t va);
        return va[OFF_W +: INDEX_W];
    endfunction

    function automatic ppn_t page_of(input vaddr_t va);
        return va[ADDR_W-1 -: PPN_W];
    endfunction

    function automatic vaddr_t fill_address(input ppn_t ppn, input vaddr_t va);
        return {ppn, va[PAGE_OFF_W-1:OFF_W], {OFF_W{1'b0}}};
    endfunction

endpackage

// File: rtl/pidx_tag_store.sv
module pidx_tag_store #(
    parameter int INDEX_W = 10,
    parameter int TAG_W   = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic [INDEX_W-1:0] rd_idx,
    output logic               rd_valid,
    output logic [TAG_W-1:0]   rd_tag,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0]   wr_tag
);
    localparam int DEPTH = 1 << INDEX_W;

    logic [DEPTH-1:0] present_q;
    logic [TAG_W-1:0] tag_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            present_q <= '0;
        end else if (wr_en) begin
            present_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_tag   <= '0;
        end else if (rd_en) begin
            rd_valid <= present_q[rd_idx];
            rd_tag   <= tag_mem[rd_idx];
        end
    end

endmodule

// File: rtl/pidx_data_store.sv
module pidx_data_store #(
    parameter int INDEX_W = 10,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rd_en,
    input  logic [INDEX_W-1:0] rd_idx,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0]  wr_data
);
    localparam int DEPTH = 1 << INDEX_W;

    logic [DATA_W-1:0] word_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            word_mem[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= word_mem[rd_idx];
        end
    end

endmodule

// File: rtl/pidx_decide.sv
module pidx_decide
    import pidx_pkg::*;
(
    input  logic     look_valid,
    input  logic     line_valid,
    input  ppn_t     line_tag,
    input  logic     xl_hit,
    input  ppn_t     xl_ppn,
    output outcome_e outcome
);
    logic tag_equal;

    assign tag_equal = line_valid && (line_tag == xl_ppn);

    always_comb begin
        if (!look_valid) begin
            outcome = OUT_NONE;
        end else if (!xl_hit) begin
            outcome = OUT_WALK;
        end else if (tag_equal) begin
            outcome = OUT_HIT;
        end else begin
            outcome = OUT_FILL;
        end
    end

endmodule

// File: rtl/pidx_cache_ctrl.sv
module pidx_cache_ctrl
    import pidx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    output logic              req_ready,
    output logic              tlb_query_valid,
    output logic [PPN_W-1:0]  tlb_query_vpn,
    input  logic              tlb_hit,
    input  logic [PPN_W-1:0]  tlb_ppn,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_paddr,
    input  logic              mem_resp_valid,
    input  logic [DATA_W-1:0] mem_resp_data,
    output logic              xlate_req_valid,
    output logic [ADDR_W-1:0] xlate_req_vaddr
);
    ctl_state_e st_q, st_d;
    stage_t     look_q, look_d;
    pending_t   pend_q;
    outcome_e   outcome;

    logic   accept;
    logic   rd_en;
    index_t rd_idx;
    logic   line_valid;
    ppn_t   line_tag;
    word_t  line_word;
    logic   fill_wr;

    // Compare cycle: array outputs meet the translation result.
    pidx_decide u_decide (
        .look_valid (look_q.valid),
        .line_valid (line_valid),
        .line_tag   (line_tag),
        .xl_hit     (tlb_hit),
        .xl_ppn     (tlb_ppn),
        .outcome    (outcome)
    );

    assign req_ready = (st_q == ST_RUN) && (outcome != OUT_FILL);
    assign accept    = req_valid && req_ready;

    // Array read uses untranslated displacement bits only.
    assign rd_en  = accept || (st_q == ST_REPLAY);
    assign rd_idx = (st_q == ST_REPLAY) ? line_index(pend_q.vaddr) : line_index(req_vaddr);

    assign fill_wr = (st_q == ST_WAIT) && mem_resp_valid;

    pidx_tag_store #(
        .INDEX_W (INDEX_W),
        .TAG_W   (PPN_W)
    ) u_tags (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_idx   (rd_idx),
        .rd_valid (line_valid),
        .rd_tag   (line_tag),
        .wr_en    (fill_wr),
        .wr_idx   (line_index(pend_q.vaddr)),
        .wr_tag   (pend_q.ppn)
    );

    pidx_data_store #(
        .INDEX_W (INDEX_W),
        .DATA_W  (DATA_W)
    ) u_words (
        .clk     (clk),
        .rd_en   (rd_en),
        .rd_idx  (rd_idx),
        .rd_data (line_word),
        .wr_en   (fill_wr),
        .wr_idx  (line_index(pend_q.vaddr)),
        .wr_data (mem_resp_data)
    );

    always_comb begin
        st_d   = st_q;
        look_d = '{valid: accept, vaddr: req_vaddr};
        unique case (st_q)
            ST_RUN: begin
                if (outcome == OUT_FILL) begin
                    st_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_resp_valid) begin
                    st_d = ST_REPLAY;
                end
            end
            ST_REPLAY: begin
                st_d   = ST_RUN;
                look_d = '{valid: 1'b1, vaddr: pend_q.vaddr};
            end
            default: st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_RUN;
            look_q <= '0;
            pend_q <= '0;
        end else begin
            st_q   <= st_d;
            look_q <= look_d;
            if (st_q == ST_RUN && outcome == OUT_FILL) begin
                pend_q <= '{vaddr: look_q.vaddr, ppn: tlb_ppn};
            end
        end
    end

    assign tlb_query_valid = look_q.valid;
    assign tlb_query_vpn   = page_of(look_q.vaddr);

    assign resp_valid      = (outcome == OUT_HIT);
    assign resp_data       = line_word;
    assign mem_req_valid   = (outcome == OUT_FILL);
    assign mem_req_paddr   = fill_address(tlb_ppn, look_q.vaddr);
    assign xlate_req_valid = (outcome == OUT_WALK);
    assign xlate_req_vaddr = look_q.vaddr;

endmodule

// File: rtl/pidx_cache_chk.sv
module pidx_cache_chk
    import pidx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              tlb_hit,
    input logic [PPN_W-1:0]  tlb_ppn,
    input logic              tlb_query_valid,
    input logic              resp_valid,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_paddr,
    input logic              mem_resp_valid,
    input logic              xlate_req_valid,
    input logic [ADDR_W-1:0] look_vaddr,
    input logic              waiting
);
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        $onehot0({resp_valid, mem_req_valid, xlate_req_valid})); // R7

    AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> req_ready); // R1

    AST_STALL_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !req_ready); // R5

    AST_FILL_FRAME: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> mem_req_paddr[ADDR_W-1 -: PPN_W] == tlb_ppn); // R3

    AST_FILL_OFFSET: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> mem_req_paddr[PAGE_OFF_W-1:0] == {look_vaddr[PAGE_OFF_W-1:OFF_W], {OFF_W{1'b0}}}); // R3

    AST_WALK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (tlb_query_valid && !tlb_hit) |-> (!mem_req_valid && !resp_valid)); // R4

    AST_HIT_NEEDS_XLATE: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> tlb_hit); // R2

    AST_REPLAY_HITS: assert property (@(posedge clk) disable iff (rst)
        (mem_resp_valid && waiting) |-> ##2 resp_valid); // R6

endmodule

bind pidx_cache_ctrl pidx_cache_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .req_ready       (req_ready),
    .tlb_hit         (tlb_hit),
    .tlb_ppn         (tlb_ppn),
    .tlb_query_valid (tlb_query_valid),
    .resp_valid      (resp_valid),
    .mem_req_valid   (mem_req_valid),
    .mem_req_paddr   (mem_req_paddr),
    .mem_resp_valid  (mem_resp_valid),
    .xlate_req_valid (xlate_req_valid),
    .look_vaddr      (look_q.vaddr),
    .waiting         (st_q == pidx_pkg::ST_WAIT)
);

// File: tb/pidx_cache_ctrl_bench.sv
module pidx_cache_ctrl_bench;

    localparam int K_HIT  = 1;
    localparam int K_FILL = 2;
    localparam int K_WALK = 3;

    typedef struct {
        int          kind;
        logic [31:0] val;
        string       rq;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready;
    logic        tlb_query_valid;
    logic [19:0] tlb_query_vpn;
    logic        tlb_hit;
    logic [19:0] tlb_ppn;
    logic        resp_valid;
    logic [31:0] resp_data;
    logic        mem_req_valid;
    logic [31:0] mem_req_paddr;
    logic        mem_resp_valid = 1'b0;
    logic [31:0] mem_resp_data = '0;
    logic        xlate_req_valid;
    logic [31:0] xlate_req_vaddr;

    int checks = 0;
    int fails  = 0;
    bit running = 1'b0;
    bit expect_stall = 1'b0;
    exp_t sb[$];

    bit          ref_v [1024];
    logic [19:0] ref_t [1024];

    always #10 clk = ~clk;

    pidx_cache_ctrl u_pidx_cache_ctrl (.*);

    // Translation model: pages ending in hex F miss; frame drops the lowest page nibble.
    always_comb begin
        tlb_hit = tlb_query_vpn[3:0] != 4'hF;
        tlb_ppn = {4'hA, tlb_query_vpn[19:4]};
    end

    function automatic logic [31:0] mem_word(input logic [31:0] pa);
        return {pa[31:12] ^ 20'h3C5A7, pa[11:0]} ^ 32'h0F0F_0000;
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Driver: compute expectations from the reference line table, then present the request.
    task automatic send(input logic [31:0] va, input string rq);
        logic [19:0] vpn;
        logic [19:0] ppn;
        logic [9:0]  idx;
        logic [31:0] pa;
        vpn = va[31:12];
        ppn = {4'hA, vpn[19:4]};
        idx = va[11:2];
        pa  = {ppn, va[11:2], 2'b00};
        if (vpn[3:0] == 4'hF) begin
            sb.push_back('{K_WALK, va, rq});
        end else if (ref_v[idx] && ref_t[idx] == ppn) begin
            sb.push_back('{K_HIT, mem_word(pa), rq});
        end else begin
            sb.push_back('{K_FILL, pa, rq});
            sb.push_back('{K_HIT, mem_word(pa), rq});
            ref_v[idx] = 1'b1;
            ref_t[idx] = ppn;
        end
        req_valid = 1'b1;
        req_vaddr = va;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Memory model: answers each request three cycles after seeing it.
    int          mem_cnt = 0;
    logic [31:0] mem_addr = '0;
    always @(negedge clk) begin
        mem_resp_valid = 1'b0;
        if (mem_cnt != 0) begin
            mem_cnt--;
            if (mem_cnt == 0) begin
                mem_resp_valid = 1'b1;
                mem_resp_data  = mem_word(mem_addr);
            end
        end
        #2;
        if (mem_req_valid) begin
            mem_addr = mem_req_paddr;
            mem_cnt  = 3;
        end
    end

    // Monitor: pop and compare as outcomes appear.
    always @(negedge clk) begin
        #2;
        if (running) begin
            if (expect_stall) begin
                check(!req_ready, "R5", "ready while miss pending", 32'(req_ready), 32'd0);
                expect_stall = 1'b0;
            end
            if (resp_valid || mem_req_valid || xlate_req_valid) begin
                int          k;
                logic [31:0] v;
                k = resp_valid ? K_HIT : (mem_req_valid ? K_FILL : K_WALK);
                v = resp_valid ? resp_data : (mem_req_valid ? mem_req_paddr : xlate_req_vaddr);
                check(32'($countones({resp_valid, mem_req_valid, xlate_req_valid})) == 1,
                      "R7", "outcome count",
                      32'($countones({resp_valid, mem_req_valid, xlate_req_valid})), 32'd1);
                if (mem_req_valid) expect_stall = 1'b1;
                if (sb.size() == 0) begin
                    check(1'b0, "R2", "unexpected outcome kind", 32'(k), 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(k == e.kind, e.rq, "outcome kind", 32'(k), 32'(e.kind));
                    check(v == e.val, e.rq, "outcome value", v, e.val);
                end
            end
        end
    end

    task automatic drain();
        int n;
        n = 0;
        while (sb.size() != 0 && n < 200) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            ref_v[i] = 1'b0;
            ref_t[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #2;
        // R1: reset state at the ports
        check(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);
        check(!resp_valid && !mem_req_valid && !xlate_req_valid, "R1", "quiet after reset",
              {29'd0, resp_valid, mem_req_valid, xlate_req_valid}, 32'd0);
        @(negedge clk);
        running = 1'b1;

        // R1, R3, R6: cold miss, refill, replayed hit
        send(32'h0001_2344, "R3");
        drain();
        // R2: same line, different byte offset hits
        send(32'h0001_2345, "R2");
        send(32'h0001_2344, "R2");
        // R9: synonym page shares the line
        send(32'h0001_3344, "R9");
        // R4: translation miss, then original line still hits
        send(32'h0001_F344, "R4");
        send(32'h0001_2344, "R4");
        drain();
        // R8: different frame, same displacement evicts, then original misses again
        send(32'h0012_0344, "R8");
        drain();
        send(32'h0001_2344, "R8");
        drain();
        // R2: displacement extremes
        send(32'h0004_0FFC, "R2");
        send(32'h0004_0000, "R2");
        drain();
        send(32'h0004_0FFC, "R2");
        send(32'h0004_0000, "R2");
        // R2, R6: fill a run of lines, then stream hits back to back
        for (int i = 0; i < 16; i++) send(32'h0007_0000 + 32'(i * 4), "R6");
        drain();
        for (int i = 0; i < 16; i++) send(32'h0007_0000 + 32'(i * 4), "R2");
        // R5: miss directly followed by another request
        send(32'h0009_0100, "R5");
        send(32'h0009_0104, "R5");
        drain();
        check(sb.size() == 0, "R2", "scoreboard empty", 32'(sb.size()), 32'd0);
        running = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule